// File: doc/BRIEF.md
# Floppy Port Soft-Switch Sequencer

This block sits behind a 16-location I/O window and turns plain accesses into state changes for a floppy disk port. Any access, read or write, to certain offsets sets or clears a latch: four stepper phase latches, a drive-enable latch, a drive-select latch, and two routing latches named Q6 and Q7. The routing latches, together with whether the drive is currently active, decide which internal register the data of that same access reaches. Reads can return the data register, a status byte, or a handshake byte supplied from outside. Writes can land in the data register or in a five-bit mode register that cannot be read back directly.

The block drives two drive-select lines. It also implements a turn-off delay: when mode bit 2 is clear, disabling the drive keeps it active for `OFF_DELAY` clock cycles, which is nominally one second. Enabling the drive again during that countdown cancels it. Bit-cell coding and the data shift register are outside this block. The data register here is a plain holding register, and the handshake byte arrives on an input port.

Top module: `fdc_switch_seq`

## Requirements
- R1: An access (`acc`=1) at offsets 0x0 to 0x7 writes `phase[addr[2:1]]` with `addr[0]`, so an even offset clears that phase and an odd offset sets it.
- R2: Offset 0x8 clears the drive-enable latch and offset 0x9 sets it. Offset 0xA selects drive 1 and offset 0xB selects drive 2.
- R3: `drv_on` is high while the enable latch is set or the turn-off countdown is running. `dr1`/`dr2` are 0/0 while `drv_on` is low, 1/0 for drive 1, and 0/1 for drive 2.
- R4: Offsets 0xC and 0xD clear and set Q6, and offsets 0xE and 0xF clear and set Q7. The routing for an access uses the latch and drive-active state that hold after that access has applied its own latch change.
- R5: A read with Q7=0 and Q6=0 returns the data register when the drive is active, and 0xFF when it is not.
- R6: A read with Q7=0 and Q6=1 returns the status byte {2'b00, drive active, mode[4:0]}. A read with Q7=1 and Q6=0 returns `hs_in`. A read with Q7=1 and Q6=1 returns 0x00. `rdata` takes the value at the clock edge of the read access and holds it until the next read.
- R7: A write with Q7=1 and Q6=1 stores `wdata` into the data register when the drive is active, and stores `wdata[4:0]` into the mode register when it is not. Writes under any other Q setting change neither register.
- R8: Offset 0x8 with the drive enabled and mode bit 2 equal to 0 keeps `drv_on` high for exactly `OFF_DELAY` clock edges, counting the edge of the access. With mode bit 2 equal to 1, `drv_on` drops at the edge of the access.
- R9: Offset 0x9 during a countdown cancels the countdown and leaves the drive active.
- R10: `hs_async` reflects mode bit 1 (1 = asynchronous handshake). `clk8m` reflects mode bit 4 (1 = 8 MHz read clock).
- R11: Reset (`rst_n`=0) clears the phases, Q6, Q7, the enable latch, the countdown, the mode register, the data register and `rdata`, and selects drive 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc | input | 1 | Access strobe for one cycle |
| we | input | 1 | 1 = write access, 0 = read access |
| addr | input | 4 | Offset within the window |
| wdata | input | 8 | Write data |
| hs_in | input | 8 | Handshake byte from the transfer logic |
| rdata | output | 8 | Read result, registered |
| phase | output | 4 | Stepper phase latches |
| drv_on | output | 1 | Drive active |
| dr1 | output | 1 | Drive 1 select |
| dr2 | output | 1 | Drive 2 select |
| data_q | output | 8 | Data register |
| hs_async | output | 1 | Asynchronous handshake selected |
| clk8m | output | 1 | 8 MHz read clock selected |

## Verification
The bench builds the block with `OFF_DELAY` set to 20. At that value the full turn-off countdown runs in a few dozen cycles, so the bench can count the exact edge on which `drv_on` falls. The short countdown also leaves room to issue further accesses while it is still running. That makes it possible to check that a Q7/Q6=11 write during the countdown reaches the data register and not the mode register, and that re-enabling the drive mid-count cancels the drop.

// File: rtl/fdc_switch_seq.sv
module fdc_switch_seq #(
  parameter int OFF_DELAY = 7_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic [7:0] hs_in,
  output logic [7:0] rdata,
  output logic [3:0] phase,
  output logic       drv_on,
  output logic       dr1,
  output logic       dr2,
  output logic [7:0] data_q,
  output logic       hs_async,
  output logic       clk8m
);
  localparam int CW = $clog2(OFF_DELAY + 1);
  localparam logic [CW-1:0] LOAD = CW'(OFF_DELAY);

  logic          en_q, sel2_q, q6_q, q7_q;
  logic [4:0]    mode_q;
  logic [CW-1:0] cnt_q;

  logic          en_n, sel2_n, q6_n, q7_n, act_n;
  logic [CW-1:0] cnt_n;
  logic [7:0]    rd_val;

  wire hit_off = acc && addr == 4'h8;
  wire hit_on  = acc && addr == 4'h9;

  always_comb begin
    en_n   = en_q;
    sel2_n = sel2_q;
    q6_n   = q6_q;
    q7_n   = q7_q;
    if (acc) begin
      case (addr)
        4'h8: en_n   = 1'b0;
        4'h9: en_n   = 1'b1;
        4'hA: sel2_n = 1'b0;
        4'hB: sel2_n = 1'b1;
        4'hC: q6_n   = 1'b0;
        4'hD: q6_n   = 1'b1;
        4'hE: q7_n   = 1'b0;
        4'hF: q7_n   = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (hit_on)                             cnt_n = '0;
    else if (hit_off && en_q && !mode_q[2]) cnt_n = LOAD;
    else if (cnt_q != '0)                   cnt_n = cnt_q - 1'b1;
    else                                    cnt_n = '0;
  end

  assign act_n = en_n | (cnt_n != '0);

  always_comb begin
    case ({q7_n, q6_n})
      2'b00:   rd_val = act_n ? data_q : 8'hFF;
      2'b01:   rd_val = {2'b00, act_n, mode_q};
      2'b10:   rd_val = hs_in;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      en_q   <= 1'b0;
      sel2_q <= 1'b0;
      q6_q   <= 1'b0;
      q7_q   <= 1'b0;
      cnt_q  <= '0;
      mode_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      en_q   <= en_n;
      sel2_q <= sel2_n;
      q6_q   <= q6_n;
      q7_q   <= q7_n;
      cnt_q  <= cnt_n;
      if (acc && !addr[3]) phase[addr[2:1]] <= addr[0];
      if (acc && !we) rdata <= rd_val;
      if (acc && we && q7_n && q6_n) begin
        if (act_n) data_q <= wdata;
        else       mode_q <= wdata[4:0];
      end
    end
  end

  assign drv_on   = en_q | (cnt_q != '0);
  assign dr1      = drv_on & ~sel2_q;
  assign dr2      = drv_on & sel2_q;
  assign hs_async = mode_q[1];
  assign clk8m    = mode_q[4];

  AST_PHASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !addr[3]) |=> phase[$past(addr[2:1])] == $past(addr[0])); // R1
  AST_DR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dr1 && dr2)); // R3
  AST_DR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_on |-> (!dr1 && !dr2)); // R3
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && we && !(q7_n && q6_n)) |=> ($stable(data_q) && $stable(mode_q))); // R7
  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_off && en_q && !mode_q[2]) |=> drv_on); // R8
  AST_DELAY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_off && cnt_q == '0 && mode_q[2]) |=> !drv_on); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_on |=> (drv_on && cnt_q == '0)); // R9
endmodule

// File: tb/fdc_switch_seq_tb_top.sv
module fdc_switch_seq_tb_top;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, hs_in = '0;
  logic [7:0] rdata, data_q;
  logic [3:0] phase;
  logic drv_on, dr1, dr2, hs_async, clk8m;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fdc_switch_seq #(.OFF_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .we(we), .addr(addr), .wdata(wdata),
    .hs_in(hs_in), .rdata(rdata), .phase(phase), .drv_on(drv_on), .dr1(dr1),
    .dr2(dr2), .data_q(data_q), .hs_async(hs_async), .clk8m(clk8m));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(logic [3:0] a, logic w = 1'b0, logic [7:0] d = 8'h00);
    @(negedge clk);
    acc = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    acc = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 rdata", rdata, 8'h00);
    chk("R11 drive", {drv_on, dr1, dr2}, 3'b000);
    chk("R11 phase", phase, 4'h0);
    chk("R11 data", data_q, 8'h00);
    chk("R11 mode outs", {hs_async, clk8m}, 2'b00);
    op(4'hC);
    chk("R5 idle data read", rdata, 8'hFF);
    op(4'hD);
    chk("R11 status after reset", rdata, 8'h00);
    op(4'h9);
    chk("R11 drive 1 selected", {dr1, dr2}, 2'b10);
    op(4'h8);
  endtask

  task automatic t_phase();
    op(4'h1); op(4'h7); op(4'h3);
    chk("R1 phase set", phase, 4'b1011);
    op(4'h6, 1'b1, 8'hFF);
    chk("R1 phase clear", phase, 4'b0011);
  endtask

  task automatic t_select();
    op(4'h9);
    chk("R2 R3 drive1", {drv_on, dr1, dr2}, 3'b110);
    op(4'hB);
    chk("R2 R3 drive2", {drv_on, dr1, dr2}, 3'b101);
    op(4'hA);
    chk("R2 R3 back to drive1", {dr1, dr2}, 2'b10);
  endtask

  task automatic t_delay();
    op(4'h8);
    chk("R8 held at disable", {drv_on, dr1}, 2'b11);
    repeat (DLY - 1) @(negedge clk);
    chk("R8 held last cycle", drv_on, 1'b1);
    @(negedge clk);
    chk("R8 dropped", {drv_on, dr1, dr2}, 3'b000);
  endtask

  task automatic t_write_during_delay();
    op(4'h9); op(4'h8);
    op(4'hD);
    op(4'hF, 1'b1, 8'h5A);
    chk("R7 R4 data write while counting", data_q, 8'h5A);
    repeat (2 * DLY) @(negedge clk);
    op(4'hE);
    chk("R7 mode untouched", rdata, 8'h00);
  endtask

  task automatic t_mode();
    op(4'hF, 1'b1, 8'hF6);
    chk("R10 mode outs", {hs_async, clk8m}, 2'b11);
    chk("R7 data untouched by mode write", data_q, 8'h5A);
    op(4'hE);
    chk("R6 status", rdata, 8'h16);
    op(4'hD, 1'b1, 8'hFF);
    op(4'hD);
    chk("R7 write in Q=01 ignored", rdata, 8'h16);
    op(4'h9); op(4'h8);
    chk("R8 immediate drop", drv_on, 1'b0);
  endtask

  task automatic t_routing();
    hs_in = 8'hA5;
    op(4'hF);
    chk("R6 Q=11 read", rdata, 8'h00);
    op(4'hC);
    chk("R6 R4 handshake read", rdata, hs_in);
    op(4'h9);
    op(4'hD, 1'b1, 8'h3C);
    chk("R7 data write active", data_q, 8'h3C);
    op(4'hE);
    chk("R6 status active", rdata, 8'h36);
    op(4'hC);
    chk("R5 data read active", rdata, 8'h3C);
  endtask

  task automatic t_cancel();
    op(4'h8);
    op(4'hD); op(4'hF, 1'b1, 8'h00);
    op(4'hE); op(4'hC);
    chk("R10 mode cleared", {hs_async, clk8m}, 2'b00);
    op(4'h9); op(4'h8);
    repeat (5) @(negedge clk);
    op(4'h9);
    repeat (DLY + 5) @(negedge clk);
    chk("R9 cancel keeps drive", drv_on, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_phase();
    t_select();
    t_delay();
    t_write_during_delay();
    t_mode();
    t_routing();
    t_cancel();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule